// File: doc/BRIEF.md
# Receive Burst End Interrupt Detector

This block decides when a burst of incoming packets has finished and then raises an interrupt without waiting for the normal coalescing timers. It looks at the receive buffer only when a return descriptor has just been written back to host memory. If the buffer holds no packet data at that moment, it loads a programmable count and counts down. The count covers the short idle gaps between packets of one burst. If a new packet starts arriving before the count runs out, the detector drops back to idle without raising anything. If the count expires quietly, it sends a one-cycle interrupt request.

The request goes to the message-signalled interrupt logic. A mode bit selects whether the request targets only vector 0 or every vector. The buffer occupancy is given as two counts: blocks in use, and the blocks within that figure that are only reserved by pre-allocation. The detector takes the buffer as empty when every block in use is a reservation. Descriptor DMA, buffer storage and message generation all live outside this block.

Top module: `rx_burst_end_irq`

## Requirements
- R1: A countdown starts only at a clock edge where the detector is idle and all of these hold: `cfg_enable_i`=1, `desc_done_i`=1, the buffer is empty, and `pkt_arrive_i`=0. In any other case the detector stays idle.
- R2: The buffer counts as empty when `buf_filled_i` <= `buf_rsvd_i`, so pre-allocated reservations are discounted. A descriptor-done event that finds the buffer not empty leaves the detector idle and produces no interrupt.
- R3: An arrival pulse in any cycle of the countdown ends it with no interrupt. This includes the cycle in which the count is already zero, where the arrival takes priority over firing.
- R4: Suppose the starting edge samples `desc_done_i` and `cfg_preload_i`=P. With no arrival, the interrupt output is high for exactly one cycle, just after the (P+1)-th rising edge that follows the starting edge. P=0 therefore fires one edge after the start, and P is 16 bits wide.
- R5: When `cfg_enable_i` is 0, the detector never fires. Clearing it during a countdown returns the detector to idle at the next edge, and no interrupt follows.
- R6: If `cfg_all_vec_i` is 1 in the cycle the count expires, the pulse appears on `irq_all_o`. If it is 0, the pulse appears on `irq_vec0_o`. The two outputs are never high together.
- R7: A descriptor-done event during a countdown neither restarts it nor changes it. After firing, the detector is idle again and re-arms on the next descriptor-done event.
- R8: During and just after synchronous active-low reset, both interrupt outputs are 0 and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable_i | input | 1 | Turns the burst-end interrupt on |
| cfg_all_vec_i | input | 1 | 1: target every vector, 0: target vector 0 only |
| cfg_preload_i | input | 16 | Countdown start value |
| desc_done_i | input | 1 | Pulse: a return descriptor write to host memory has completed |
| pkt_arrive_i | input | 1 | Pulse: a new packet has begun entering the receive buffer |
| buf_filled_i | input | 10 | Buffer blocks in use, reservations included |
| buf_rsvd_i | input | 10 | Blocks in use that are only pre-allocated |
| irq_vec0_o | output | 1 | One-cycle interrupt request for vector 0 |
| irq_all_o | output | 1 | One-cycle interrupt request for all vectors |

## Verification
A descriptor-done event sampled at edge k with preload P is expected to give a pulse that can be seen only after edge k+P+1. The bench drives inputs on falling edges and counts falling edges from the starting edge. For each index j in a window that reaches past the due point, it compares both outputs with the value expected at that index: high only when j equals P+1 and the scenario should fire. Arrivals, enable clears, mode flips and extra descriptor-done pulses are placed at chosen indices in the same window, and an arrival at index P lands exactly on the expiry cycle. Suppressed scenarios are checked to stay low through the whole window.

// File: rtl/rx_burst_end_pkg.sv
// Package: shared types for the receive burst end interrupt detector.
// Assumes: a two-state controller, idle or counting.
package rx_burst_end_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } burst_state_e;
endpackage

// File: rtl/rx_buf_empty_check.sv
// Module: decides whether the receive buffer holds packet data.
// Assumes: rsvd counts blocks that are inside filled but only reserved by
// pre-allocation, so the buffer counts as empty when filled <= rsvd.
module rx_buf_empty_check #(
    parameter int OCC_W = 10
) (
    input  logic [OCC_W-1:0] filled_i,
    input  logic [OCC_W-1:0] rsvd_i,
    output logic             empty_o
);
    // Purpose: leave reservations out of the occupancy test.
    always_comb begin
        empty_o = (filled_i <= rsvd_i);
    end
endmodule

// File: rtl/rx_burst_countdown.sv
// Module: idle/count controller with the debounce down-counter.
// Assumes: pulse inputs last one cycle. fire_o is combinational and is
// high in the cycle in which the count expires without an arrival.
module rx_burst_countdown
    import rx_burst_end_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             done_i,
    input  logic             empty_i,
    input  logic             arrive_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic             fire_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    burst_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;
    logic             expire;

    // Purpose: decide whether a countdown starts this cycle.
    always_comb begin
        start = (state_q == ST_IDLE) && enable_i && done_i && empty_i && !arrive_i;
    end

    // Purpose: decide whether a running count expires quietly this cycle.
    always_comb begin
        expire = (state_q == ST_COUNT) && enable_i && !arrive_i && (cnt_q == '0);
    end

    assign fire_o = expire;

    // Purpose: advance the state and the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_COUNT;
                        cnt_q   <= preload_i;
                    end
                end
                default: begin
                    if (!enable_i || arrive_i || expire) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // R1 / R2: a start loads the preload value.
    a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_COUNT) && (cnt_q == $past(preload_i)));

    // R2: a non-empty buffer keeps the controller idle.
    a_r2_busy_buffer_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !empty_i) |=> (state_q == ST_IDLE));

    // R3: an arrival during counting cancels without firing.
    a_r3_arrival_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COUNT) && arrive_i) |-> !fire_o ##1 (state_q == ST_IDLE));

    // R4: a quiet count steps down by one.
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COUNT) && enable_i && !arrive_i && (cnt_q != '0))
        |=> (state_q == ST_COUNT) && (cnt_q == $past(cnt_q) - ONE));

    // R5: clearing enable forces idle.
    a_r5_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == ST_IDLE));

    // R7: after firing the controller is idle.
    a_r7_fire_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rx_irq_route.sv
// Module: turns a fire event into a registered one-cycle request on the
// vector-0 output or the all-vectors output.
// Assumes: mode is sampled in the cycle of the fire event.
module rx_irq_route (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic all_mode_i,
    output logic vec0_o,
    output logic all_o
);
    // Purpose: register the routed request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec0_o <= 1'b0;
            all_o  <= 1'b0;
        end else begin
            vec0_o <= fire_i && !all_mode_i;
            all_o  <= fire_i && all_mode_i;
        end
    end

    // R6: the outputs never overlap.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec0_o && all_o));

    // R6: the selected output follows a fire event.
    a_r6_routed: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (all_mode_i ? all_o : vec0_o) == 1'b0 ? 1'b0 :
                   ($past(all_mode_i) ? all_o : vec0_o));

    // R4: each request lasts one cycle.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (vec0_o || all_o) |=> !(vec0_o || all_o));
endmodule

// File: rtl/rx_burst_end_irq.sv
// Module: top of the receive burst end interrupt detector.
// Assumes: synchronous active-low reset, and one-cycle pulse inputs on
// desc_done_i and pkt_arrive_i.
module rx_burst_end_irq #(
    parameter int CNT_W = 16,
    parameter int OCC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable_i,
    input  logic             cfg_all_vec_i,
    input  logic [CNT_W-1:0] cfg_preload_i,
    input  logic             desc_done_i,
    input  logic             pkt_arrive_i,
    input  logic [OCC_W-1:0] buf_filled_i,
    input  logic [OCC_W-1:0] buf_rsvd_i,
    output logic             irq_vec0_o,
    output logic             irq_all_o
);
    logic buf_empty;
    logic fire;

    rx_buf_empty_check #(.OCC_W(OCC_W)) u_empty (
        .filled_i (buf_filled_i),
        .rsvd_i   (buf_rsvd_i),
        .empty_o  (buf_empty)
    );

    rx_burst_countdown #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (cfg_enable_i),
        .done_i    (desc_done_i),
        .empty_i   (buf_empty),
        .arrive_i  (pkt_arrive_i),
        .preload_i (cfg_preload_i),
        .fire_o    (fire)
    );

    rx_irq_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .all_mode_i (cfg_all_vec_i),
        .vec0_o     (irq_vec0_o),
        .all_o      (irq_all_o)
    );

    // R5: with enable low for two edges, no request appears.
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable_i && $past(!cfg_enable_i)) |=> !(irq_vec0_o || irq_all_o));
endmodule

// File: tb/test_rx_burst_end_irq.sv
module test_rx_burst_end_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable_i = 1'b0;
    logic        cfg_all_vec_i = 1'b0;
    logic [15:0] cfg_preload_i = '0;
    logic        desc_done_i = 1'b0;
    logic        pkt_arrive_i = 1'b0;
    logic [9:0]  buf_filled_i = '0;
    logic [9:0]  buf_rsvd_i = '0;
    logic        irq_vec0_o;
    logic        irq_all_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rx_burst_end_irq i_rx_burst_end_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enable_i  (cfg_enable_i),
        .cfg_all_vec_i (cfg_all_vec_i),
        .cfg_preload_i (cfg_preload_i),
        .desc_done_i   (desc_done_i),
        .pkt_arrive_i  (pkt_arrive_i),
        .buf_filled_i  (buf_filled_i),
        .buf_rsvd_i    (buf_rsvd_i),
        .irq_vec0_o    (irq_vec0_o),
        .irq_all_o     (irq_all_o)
    );

    task automatic check(input string req, input logic v0, input logic va,
                         input logic e0, input logic ea);
        checks++;
        if (v0 !== e0 || va !== ea) begin
            errors++;
            $display("FAIL %s: vec0/all = %b%b, expected %b%b at %0t", req, v0, va, e0, ea, $time);
        end
    endtask

    // Generic window: start pulse at edge k, then watch falling edges j=0..P+4.
    // Indices below 0 disable the event. A fire is expected only at j==P+1.
    task automatic run_window(input string req, input int p, input bit en0,
                              input bit mode0, input bit arr_with_done,
                              input int arr_at, input int off_at,
                              input int mode_at, input int redo_at,
                              input bit exp_fire);
        bit mode_eff;
        mode_eff = (mode_at >= 0 && mode_at <= p) ? ~mode0 : mode0;
        @(negedge clk);
        cfg_preload_i = 16'(p);
        cfg_enable_i  = en0;
        cfg_all_vec_i = mode0;
        desc_done_i   = 1'b1;
        pkt_arrive_i  = arr_with_done;
        @(posedge clk);
        for (int j = 0; j <= p + 4; j++) begin
            @(negedge clk);
            desc_done_i  = (j == redo_at);
            pkt_arrive_i = (j == arr_at);
            if (j == off_at)  cfg_enable_i = 1'b0;
            if (j == mode_at) cfg_all_vec_i = ~mode0;
            if (exp_fire && j == p + 1)
                check(req, irq_vec0_o, irq_all_o, ~mode_eff, mode_eff);
            else
                check(req, irq_vec0_o, irq_all_o, 1'b0, 1'b0);
        end
        @(negedge clk);
        desc_done_i   = 1'b0;
        pkt_arrive_i  = 1'b0;
        cfg_enable_i  = 1'b1;
        cfg_all_vec_i = 1'b0;
        buf_filled_i  = '0;
        buf_rsvd_i    = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 in reset", irq_vec0_o, irq_all_o, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", irq_vec0_o, irq_all_o, 1'b0, 1'b0);
    endtask

    task automatic t_basic_timing();
        run_window("R4 preload 0", 0, 1, 0, 0, -1, -1, -1, -1, 1);
        run_window("R4 preload 1", 1, 1, 0, 0, -1, -1, -1, -1, 1);
        run_window("R4 preload 7", 7, 1, 0, 0, -1, -1, -1, -1, 1);
        run_window("R4 preload 300", 300, 1, 0, 0, -1, -1, -1, -1, 1);
    endtask

    task automatic t_empty_test();
        buf_filled_i = 10'd5; buf_rsvd_i = 10'd5;
        run_window("R2 reserved only counts empty", 3, 1, 0, 0, -1, -1, -1, -1, 1);
        buf_filled_i = 10'd0; buf_rsvd_i = 10'd3;
        run_window("R2 reservations with none used", 2, 1, 0, 0, -1, -1, -1, -1, 1);
        buf_filled_i = 10'd6; buf_rsvd_i = 10'd5;
        run_window("R2 data present stays idle", 3, 1, 0, 0, -1, -1, -1, -1, 0);
    endtask

    task automatic t_start_gate();
        run_window("R1 arrival with done blocks start", 2, 1, 0, 1, -1, -1, -1, -1, 0);
    endtask

    task automatic t_cancel();
        run_window("R3 arrival mid count", 6, 1, 0, 0, 2, -1, -1, -1, 0);
        run_window("R3 arrival on expiry cycle", 4, 1, 0, 0, 4, -1, -1, -1, 0);
        run_window("R3 arrival at first count cycle", 0, 1, 0, 0, 0, -1, -1, -1, 0);
    endtask

    task automatic t_enable();
        run_window("R5 disabled throughout", 2, 0, 0, 0, -1, -1, -1, -1, 0);
        run_window("R5 enable cleared mid count", 6, 1, 0, 0, -1, 3, -1, -1, 0);
    endtask

    task automatic t_mode();
        run_window("R6 all vectors", 3, 1, 1, 0, -1, -1, -1, -1, 1);
        run_window("R6 mode flipped on expiry cycle", 3, 1, 0, 0, -1, -1, 3, -1, 1);
        run_window("R6 mode flipped after expiry", 3, 1, 1, 0, -1, -1, 5, -1, 1);
    endtask

    task automatic t_rearm();
        run_window("R7 done during count ignored", 6, 1, 0, 0, -1, -1, -1, 2, 1);
        run_window("R7 re-arm after fire", 2, 1, 0, 0, -1, -1, -1, -1, 1);
    endtask

    initial begin
        t_reset();
        cfg_enable_i = 1'b1;
        t_basic_timing();
        t_empty_test();
        t_start_gate();
        t_cancel();
        t_enable();
        t_mode();
        t_rearm();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule